// File: doc/BRIEF.md
# Pseudo-SRAM Bus Rule Monitor

This block watches the control, byte-enable and address lines of a 512K x 16 pseudo-static RAM, the kind whose cells need a periodic hidden refresh. It does not drive any memory signal. It samples every line through a two-flop synchroniser, decodes whether the memory is selected, reading or writing, and measures the lengths of intervals by counting clock cycles against parameter limits.

The monitor enforces the bus rules that let the memory finish power-up and keep refreshing itself. These rules are a deselect window after reset, a minimum and a maximum write pulse, a minimum address-hold time during continuous selection, and a cap on back-to-back write activity that has no real break in it. Each broken rule raises a sticky flag and a one-cycle pulse. A small code records which rule failed first, so software or a simulation log can find the root cause after a burst of follow-on errors. All limits are parameters counted in clock cycles. The defaults assume a sampling clock of about 250 MHz.

Top module: `psramBusChecker`

## Requirements
- R1: While reset is asserted, errFlags, errPulse and firstErr are all zero and memState reads 0 (uninitialised).
- R2: For PWRUP_CYC cycles of synchronised time after reset release, memState stays 0. Any selection seen in that window (selLoN low with selHi high) sets flag bit 0. After the window, memState leaves 0 and never returns to it.
- R3: An access is active only when selLoN is low, selHi is high and at least one of loByteN or hiByteN is low. A write is an active access with wrEnN low. memState is 1 for standby (including a selection with both byte enables high), 2 for an active read and 3 for a write. A selection with no byte enable produces no write rule flag.
- R4: A write that ends after fewer than MIN_WR_CYC consecutive cycles sets flag bit 1. A write of exactly MIN_WR_CYC cycles does not.
- R5: A write that is still going on after MAX_WR_CYC cycles sets flag bit 2, exactly once per write. A write of exactly MAX_WR_CYC cycles does not.
- R6: While the memory stays selected, an address change that comes fewer than MIN_ADDR_CYC cycles after the previous change (or after the start of the selection) sets flag bit 3. An address that changes while deselected is not checked.
- R7: Write activity counted from its first write cycle, including non-write gaps shorter than MIN_GAP_CYC cycles, that runs longer than MAX_BUSY_CYC cycles sets flag bit 4.
- R8: A non-write gap of at least MIN_GAP_CYC cycles restarts the busy timer of R7, so a long series of writes separated by such gaps raises no flag.
- R9: Each flag stays set until a one is written to the matching bit of clrErr. A clear affects only that bit.
- R10: firstErr holds the flag index plus one of the first violation after all flags were clear. If several rules break in the same cycle, the lowest index wins. firstErr holds while any flag remains set and returns to zero when the last flag is cleared.
- R11: errPulse carries a single-cycle pulse on the bit of each rule event. A rule that stays broken (a long write, a busy run) pulses once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| selLoN | input | 1 | Primary chip select of the memory, active low |
| selHi | input | 1 | Secondary chip select of the memory, active high |
| wrEnN | input | 1 | Write enable of the memory, active low |
| loByteN | input | 1 | Lower byte enable, active low |
| hiByteN | input | 1 | Upper byte enable, active low |
| wordAddr | input | ADDR_W | Word address of the memory |
| clrErr | input | 5 | Write-one-to-clear strobe per flag |
| errFlags | output | 5 | Sticky flags: 0 power-up, 1 short write, 2 long write, 3 address cycle, 4 busy run |
| errPulse | output | 5 | One-cycle event pulse per flag bit |
| firstErr | output | 3 | First violation code, flag index plus one, 0 when clear |
| memState | output | 2 | 0 uninitialised, 1 standby, 2 reading, 3 writing |

## Verification
The bench targets exact-limit boundaries: a write of exactly the minimum and exactly the maximum length, and address holds of exactly the minimum. An off-by-one counter would flag these legal cases. It drives a selection with no byte enable while the write line is low, which catches a decoder that ignores byte enables and reports phantom writes. It contrasts one-cycle gaps with gaps of the full minimum length inside long write trains. A timer that restarts on any gap would miss the busy violation, and one that never restarts would raise a false flag. Finally, a short write and an early address change are made to end in the same cycle, and flags are cleared one by one. This exposes a wrong priority order or a first-error code that is lost or overwritten too early.

// File: rtl/psramChkPkg.sv
package psramChkPkg;

  localparam int NUM_ERR = 5;

  localparam int ERR_PWRUP   = 0;
  localparam int ERR_SHORTWR = 1;
  localparam int ERR_LONGWR  = 2;
  localparam int ERR_ADDRCYC = 3;
  localparam int ERR_BUSY    = 4;

  typedef enum logic [1:0] {
    ST_UNINIT  = 2'd0,
    ST_STANDBY = 2'd1,
    ST_READ    = 2'd2,
    ST_WRITE   = 2'd3
  } memStateT;

  // Strobes from the bus decoder to the rule datapath
  typedef struct packed {
    logic inWindow;  // power-up deselect window still open
    logic sel;       // chip selected
    logic selCont;   // selected this cycle and the previous one
    logic addrChg;   // address differs from previous cycle
    logic wr;        // write overlap active
  } busStrobeT;

endpackage

// File: rtl/psramSyncStage.sv
module psramSyncStage #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [DEPTH];

  generate
    for (genvar stg = 0; stg < DEPTH; stg++) begin : gStage
      if (stg == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) pipe[stg] <= RST_VAL;
          else       pipe[stg] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) pipe[stg] <= RST_VAL;
          else       pipe[stg] <= pipe[stg-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/psramBusDecode.sv
module psramBusDecode
  import psramChkPkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int PWRUP_CYC  = 12500,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sSelLoN,
  input  logic              sSelHi,
  input  logic              sWrEnN,
  input  logic              sLoByteN,
  input  logic              sHiByteN,
  input  logic [ADDR_W-1:0] sAddr,
  output busStrobeT         strobe,
  output memStateT          memState
);

  // Synchronised samples lag by SYNC_DEPTH, so the window is stretched to match
  localparam int WIN_CYC = PWRUP_CYC + SYNC_DEPTH;
  localparam int PU_W    = $clog2(WIN_CYC + 1);
  localparam logic [PU_W-1:0] WIN_END = PU_W'(WIN_CYC);

  logic [PU_W-1:0]   puCnt;
  logic              prevSel;
  logic [ADDR_W-1:0] prevAddr;
  logic              sel, act, wr, inWindow;

  assign inWindow = (puCnt != WIN_END);
  assign sel      = !sSelLoN && sSelHi;
  assign act      = sel && (!sLoByteN || !sHiByteN);
  assign wr       = act && !sWrEnN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      puCnt    <= '0;
      prevSel  <= 1'b0;
      prevAddr <= '0;
      memState <= ST_UNINIT;
    end else begin
      if (inWindow) puCnt <= puCnt + 1'b1;
      prevSel  <= sel;
      prevAddr <= sAddr;
      if (inWindow)  memState <= ST_UNINIT;
      else if (wr)   memState <= ST_WRITE;
      else if (act)  memState <= ST_READ;
      else           memState <= ST_STANDBY;
    end
  end

  always_comb begin
    strobe.inWindow = inWindow;
    strobe.sel      = sel;
    strobe.selCont  = sel && prevSel;
    strobe.addrChg  = (sAddr != prevAddr);
    strobe.wr       = wr;
  end

endmodule

// File: rtl/psramRuleDp.sv
module psramRuleDp
  import psramChkPkg::*;
#(
  parameter int MIN_WR_CYC   = 12,
  parameter int MAX_WR_CYC   = 3750,
  parameter int MIN_ADDR_CYC = 14,
  parameter int MAX_BUSY_CYC = 3750,
  parameter int MIN_GAP_CYC  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobeT          strobe,
  input  logic [NUM_ERR-1:0] clrErr,
  output logic [NUM_ERR-1:0] errFlags,
  output logic [NUM_ERR-1:0] errPulse,
  output logic [2:0]         firstErr
);

  localparam int WR_W  = $clog2(MAX_WR_CYC + 2);
  localparam int AG_W  = $clog2(MIN_ADDR_CYC + 1);
  localparam int BZ_W  = $clog2(MAX_BUSY_CYC + 2);
  localparam int GP_W  = $clog2(MIN_GAP_CYC + 1);
  localparam logic [WR_W-1:0] WR_MIN  = WR_W'(MIN_WR_CYC);
  localparam logic [WR_W-1:0] WR_MAX  = WR_W'(MAX_WR_CYC);
  localparam logic [WR_W-1:0] WR_SAT  = WR_W'(MAX_WR_CYC + 1);
  localparam logic [AG_W-1:0] AG_MIN  = AG_W'(MIN_ADDR_CYC);
  localparam logic [BZ_W-1:0] BZ_MAX  = BZ_W'(MAX_BUSY_CYC);
  localparam logic [BZ_W-1:0] BZ_SAT  = BZ_W'(MAX_BUSY_CYC + 1);
  localparam logic [GP_W-1:0] GP_MIN  = GP_W'(MIN_GAP_CYC);

  logic [WR_W-1:0]    wrLen;
  logic [AG_W-1:0]    addrAge;
  logic [BZ_W-1:0]    busyLen;
  logic [GP_W-1:0]    gapLen;
  logic               gapDone, busyInc, ageRestart;
  logic [NUM_ERR-1:0] ev, remain;

  function automatic logic [2:0] encFirst(input logic [NUM_ERR-1:0] v);
    encFirst = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--)
      if (v[i]) encFirst = 3'(i + 1);
  endfunction

  assign gapDone    = !strobe.wr && ((gapLen + 1'b1) >= GP_MIN);
  assign busyInc    = !gapDone && (strobe.wr || busyLen != '0);
  assign ageRestart = strobe.sel && (!strobe.selCont || strobe.addrChg);

  always_comb begin
    ev = '0;
    ev[ERR_PWRUP]   = strobe.inWindow && strobe.sel;
    ev[ERR_SHORTWR] = !strobe.wr && wrLen != '0 && wrLen < WR_MIN;
    ev[ERR_LONGWR]  = strobe.wr && wrLen == WR_MAX;
    ev[ERR_ADDRCYC] = strobe.selCont && strobe.addrChg && addrAge < AG_MIN;
    ev[ERR_BUSY]    = busyInc && busyLen == BZ_MAX;
  end

  assign remain = errFlags & ~clrErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrLen    <= '0;
      addrAge  <= '0;
      busyLen  <= '0;
      gapLen   <= '0;
      errFlags <= '0;
      errPulse <= '0;
      firstErr <= '0;
    end else begin
      if (!strobe.wr)          wrLen <= '0;
      else if (wrLen != WR_SAT) wrLen <= wrLen + 1'b1;

      if (ageRestart)                         addrAge <= AG_W'(1);
      else if (strobe.sel && addrAge < AG_MIN) addrAge <= addrAge + 1'b1;

      if (strobe.wr)          gapLen <= '0;
      else if (gapLen < GP_MIN) gapLen <= gapLen + 1'b1;

      if (gapDone)                       busyLen <= '0;
      else if (busyInc && busyLen != BZ_SAT) busyLen <= busyLen + 1'b1;

      errPulse <= ev;
      errFlags <= remain | ev;
      if (remain == '0) firstErr <= (ev != '0) ? encFirst(ev) : 3'd0;
    end
  end

endmodule

// File: rtl/psramBusChecker.sv
module psramBusChecker
  import psramChkPkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int SYNC_DEPTH   = 2,
  parameter int PWRUP_CYC    = 12500,
  parameter int MIN_WR_CYC   = 12,
  parameter int MAX_WR_CYC   = 3750,
  parameter int MIN_ADDR_CYC = 14,
  parameter int MAX_BUSY_CYC = 3750,
  parameter int MIN_GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selLoN,
  input  logic              selHi,
  input  logic              wrEnN,
  input  logic              loByteN,
  input  logic              hiByteN,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [4:0]        clrErr,
  output logic [4:0]        errFlags,
  output logic [4:0]        errPulse,
  output logic [2:0]        firstErr,
  output logic [1:0]        memState
);

  localparam int BUS_W = ADDR_W + 5;
  localparam logic [BUS_W-1:0] BUS_IDLE = {5'b10111, {ADDR_W{1'b0}}};

  logic [BUS_W-1:0]  syncBus;
  logic              sSelLoN, sSelHi, sWrEnN, sLoByteN, sHiByteN;
  logic [ADDR_W-1:0] sAddr;
  busStrobeT         strobe;
  memStateT          stateInt;

  psramSyncStage #(.WIDTH(BUS_W), .DEPTH(SYNC_DEPTH), .RST_VAL(BUS_IDLE)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({selLoN, selHi, wrEnN, loByteN, hiByteN, wordAddr}),
    .dout(syncBus)
  );

  assign {sSelLoN, sSelHi, sWrEnN, sLoByteN, sHiByteN, sAddr} = syncBus;

  psramBusDecode #(.ADDR_W(ADDR_W), .PWRUP_CYC(PWRUP_CYC), .SYNC_DEPTH(SYNC_DEPTH)) uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .sSelLoN (sSelLoN),
    .sSelHi  (sSelHi),
    .sWrEnN  (sWrEnN),
    .sLoByteN(sLoByteN),
    .sHiByteN(sHiByteN),
    .sAddr   (sAddr),
    .strobe  (strobe),
    .memState(stateInt)
  );

  psramRuleDp #(
    .MIN_WR_CYC  (MIN_WR_CYC),
    .MAX_WR_CYC  (MAX_WR_CYC),
    .MIN_ADDR_CYC(MIN_ADDR_CYC),
    .MAX_BUSY_CYC(MAX_BUSY_CYC),
    .MIN_GAP_CYC (MIN_GAP_CYC)
  ) uRules (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .clrErr  (clrErr),
    .errFlags(errFlags),
    .errPulse(errPulse),
    .firstErr(firstErr)
  );

  assign memState = stateInt;

endmodule

// File: rtl/psramBusCheckerSva.sv
module psramBusCheckerSva (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] clrErr,
  input logic [4:0] errFlags,
  input logic [4:0] errPulse,
  input logic [2:0] firstErr,
  input logic [1:0] memState
);

  // R9: a set flag drops only when its clear bit was written
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(errFlags) & ~$past(clrErr)) & ~errFlags) == 5'd0));

  // R11: every pulse is mirrored by its flag
  a_r11_pulse_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse & ~errFlags) == 5'd0);

  // R10: any set flag implies a recorded first-error code
  a_r10_code_present: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags != 5'd0) |-> (firstErr != 3'd0));

  // R10: the code holds while uncleared flags remain
  a_r10_code_held: assert property (@(posedge clk) disable iff (!rstN)
    ((errFlags & ~clrErr) != 5'd0) |=> $stable(firstErr));

  // R10: only codes 0..5 exist
  a_r10_code_range: assert property (@(posedge clk) disable iff (!rstN)
    firstErr <= 3'd5);

  // R2: once out of the uninitialised state, never back
  a_r2_no_return_uninit: assert property (@(posedge clk) disable iff (!rstN)
    (memState != 2'd0) |=> (memState != 2'd0));

endmodule

bind psramBusChecker psramBusCheckerSva chk (
  .clk     (clk),
  .rstN    (rstN),
  .clrErr  (clrErr),
  .errFlags(errFlags),
  .errPulse(errPulse),
  .firstErr(firstErr),
  .memState(memState)
);

// File: tb/psramBusChecker_test.sv
module psramBusChecker_test;

  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          selLoN = 1'b1, selHi = 1'b0, wrEnN = 1'b1, loByteN = 1'b1, hiByteN = 1'b1;
  logic [AW-1:0] wordAddr = '0;
  logic [4:0]    clrErr = '0;
  logic [4:0]    errFlags, errPulse;
  logic [2:0]    firstErr;
  logic [1:0]    memState;

  int checks = 0;
  int failures = 0;
  int pc [5] = '{0, 0, 0, 0, 0};
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  psramBusChecker #(
    .ADDR_W(AW), .PWRUP_CYC(40), .MIN_WR_CYC(4), .MAX_WR_CYC(20),
    .MIN_ADDR_CYC(5), .MAX_BUSY_CYC(30), .MIN_GAP_CYC(3)
  ) uut (
    .clk(clk), .rstN(rstN), .selLoN(selLoN), .selHi(selHi), .wrEnN(wrEnN),
    .loByteN(loByteN), .hiByteN(hiByteN), .wordAddr(wordAddr), .clrErr(clrErr),
    .errFlags(errFlags), .errPulse(errPulse), .firstErr(firstErr), .memState(memState)
  );

  always @(posedge clk)
    if (rstN) for (int i = 0; i < 5; i++) pc[i] <= pc[i] + int'(errPulse[i]);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic deselect();
    selLoN = 1'b1; selHi = 1'b0; wrEnN = 1'b1; loByteN = 1'b1; hiByteN = 1'b1;
  endtask

  task automatic selRead();
    selLoN = 1'b0; selHi = 1'b1; wrEnN = 1'b1; loByteN = 1'b0; hiByteN = 1'b1;
  endtask

  task automatic doWrite(input int n);
    selLoN = 1'b0; selHi = 1'b1; loByteN = 1'b0; wrEnN = 1'b0;
    cyc(n);
    wrEnN = 1'b1;
  endtask

  task automatic clearBits(input logic [4:0] m);
    clrErr = m; cyc(1); clrErr = '0; cyc(1);
  endtask

  task automatic testReset();
    rstN = 1'b0; deselect(); cyc(5);
    check("R1 flags in reset", int'(errFlags), 0);
    check("R1 pulse in reset", int'(errPulse), 0);
    check("R1 code in reset", int'(firstErr), 0);
    check("R1 state in reset", int'(memState), 0);
    rstN = 1'b1;
  endtask

  task automatic testPowerUp();
    cyc(3);
    check("R2 uninit in window", int'(memState), 0);
    selLoN = 1'b0; selHi = 1'b1; cyc(2); deselect(); cyc(6);
    check("R2 powerup flag", int'(errFlags), 5'b00001);
    check("R10 powerup code", int'(firstErr), 1);
    cyc(50);
    check("R2 standby after window", int'(memState), 1);
    clearBits(5'h1F);
    check("R9 clear all flags", int'(errFlags), 0);
    check("R10 code cleared", int'(firstErr), 0);
  endtask

  task automatic testDecode();
    wordAddr = 19'd5; cyc(2);
    selLoN = 1'b0; selHi = 1'b1; loByteN = 1'b1; hiByteN = 1'b1; wrEnN = 1'b0; cyc(6);
    check("R3 no byte enable is standby", int'(memState), 1);
    wrEnN = 1'b1; loByteN = 1'b0; cyc(6);
    check("R3 read state", int'(memState), 2);
    loByteN = 1'b1; hiByteN = 1'b0; wrEnN = 1'b0; cyc(6);
    check("R3 upper byte write state", int'(memState), 3);
    wrEnN = 1'b1; cyc(2); deselect(); cyc(2);
    selLoN = 1'b0; selHi = 1'b0; loByteN = 1'b0; wrEnN = 1'b0; cyc(6);
    check("R3 secondary select low is standby", int'(memState), 1);
    deselect(); cyc(6);
    check("R3 no flags from decode cases", int'(errFlags), 0);
  endtask

  task automatic testShortWrite();
    int base = pc[1];
    doWrite(4); cyc(6); deselect(); cyc(6);
    check("R4 four-cycle write legal", pc[1] - base, 0);
    doWrite(3); cyc(2); deselect(); cyc(6);
    check("R4 short write flag", int'(errFlags), 5'b00010);
    check("R10 short write code", int'(firstErr), 2);
    check("R11 one short pulse", pc[1] - base, 1);
    clearBits(5'h1F);
  endtask

  task automatic testLongWrite();
    int base = pc[2];
    doWrite(20); deselect(); cyc(6);
    check("R5 max-length write legal", int'(errFlags), 0);
    doWrite(25); deselect(); cyc(6);
    check("R5 long write flag only", int'(errFlags), 5'b00100);
    check("R11 one long pulse", pc[2] - base, 1);
    check("R10 long write code", int'(firstErr), 3);
    clearBits(5'h1F);
  endtask

  task automatic testAddr();
    wordAddr = 19'd100; cyc(2);
    selRead(); cyc(5);
    wordAddr = 19'd101; cyc(5);
    wordAddr = 19'd102; cyc(6);
    deselect(); cyc(2);
    wordAddr = 19'd200; cyc(6);
    check("R6 legal address holds", int'(errFlags), 0);
    wordAddr = 19'd300; selRead(); cyc(4);
    wordAddr = 19'd301; cyc(3); deselect(); cyc(6);
    check("R6 early address change flag", int'(errFlags), 5'b01000);
    check("R10 address code", int'(firstErr), 4);
    clearBits(5'h1F);
  endtask

  task automatic testBusy();
    int base = pc[4];
    selRead(); cyc(1);
    for (int k = 0; k < 6; k++) begin
      wrEnN = 1'b0; cyc(8); wrEnN = 1'b1; cyc(3);
    end
    deselect(); cyc(6);
    check("R8 full gaps restart busy timer", int'(errFlags), 0);
    selRead(); cyc(1);
    for (int k = 0; k < 5; k++) begin
      wrEnN = 1'b0; cyc(8); wrEnN = 1'b1; cyc(1);
    end
    deselect(); cyc(6);
    check("R7 busy flag", int'(errFlags), 5'b10000);
    check("R11 one busy pulse", pc[4] - base, 1);
    check("R10 busy code", int'(firstErr), 5);
  endtask

  task automatic testSticky();
    doWrite(2); deselect(); cyc(6);
    check("R9 both flags held", int'(errFlags), 5'b10010);
    check("R10 code keeps first", int'(firstErr), 5);
    clearBits(5'b10000);
    check("R9 single bit clear", int'(errFlags), 5'b00010);
    check("R10 code held after partial clear", int'(firstErr), 5);
    clearBits(5'b00010);
    check("R9 last flag cleared", int'(errFlags), 0);
    check("R10 code reset", int'(firstErr), 0);
  endtask

  task automatic testSimultaneous();
    wordAddr = 19'd400; cyc(2);
    doWrite(2); wordAddr = 19'd401; cyc(6); deselect(); cyc(6);
    check("R10 simultaneous flags", int'(errFlags), 5'b01010);
    check("R10 lowest index wins", int'(firstErr), 2);
    cyc(20);
    check("R9 flags still held", int'(errFlags), 5'b01010);
    clearBits(5'h1F);
  endtask

  initial begin
    testReset();
    testPowerUp();
    testDecode();
    testShortWrite();
    testLongWrite();
    testAddr();
    testBusy();
    testSticky();
    testSimultaneous();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule